// File: doc/BRIEF.md
# I2C Transfer Byte-Count Sequencer

This block governs the data phase of an I2C master transfer. Software programs a segment length of 0 to 255 bytes, an end behaviour and an optional trailing packet-error-check byte, then requests a START. Once the bit engine reports that the START and address went out, the sequencer counts the per-byte completion pulses from the shift engine until the programmed length is reached.

At the end of a segment one of three things happens. With reload selected, the block raises a reload flag and holds SCL low until software supplies a fresh length, after which counting continues on the same transfer. Without reload, automatic end mode issues a one-cycle STOP request, and software end mode raises a completion flag and holds SCL low until software writes START or STOP. A pending PEC request, when reload is off, inserts one extra byte slot before that end action.

The PEC request is sticky. It is set only by writing 1 and is cleared by hardware when the PEC byte completes, when the bus engine reports a STOP or an address match, when the block is disabled, or on soft reset.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, stop_req, scl_hold, tc_flag, tcr_flag and pec_slot are all 0.
- R2: With cfg_reload=0, cfg_autoend=0 and no PEC pending, once the programmed count of byte_done pulses has arrived, tc_flag and scl_hold go to 1 and no stop_req pulse occurs. tc_flag and tcr_flag are never 1 together.
- R3: With cfg_reload=0 and cfg_autoend=1, reaching the count produces exactly one stop_req pulse of one clock, with tc_flag=0 and scl_hold=0.
- R4: With cfg_reload=1, reaching the count sets tcr_flag and scl_hold regardless of cfg_autoend, with no stop_req pulse.
- R5: A register write while tcr_flag is set loads the new count, clears tcr_flag, releases scl_hold and resumes counting from zero with no stop_req, following the newly written end mode.
- R6: With a PEC request pending and reload off, pec_slot is 1 while one extra byte is awaited after the count. The end action of R2 or R3 follows that byte, and pec_slot is 0 at all other times.
- R7: Writing cfg_pec_set=1 sets the PEC request, and a write with cfg_pec_set=0 leaves it unchanged. While reload is on, the request causes no PEC slot.
- R8: The PEC request is cleared by completion of the PEC byte, by bus_stop_seen, by addr_match, by periph_en=0 and by soft_rst.
- R9: A write arriving while a START is pending (after a write with cfg_start=1 and before start_sent) does not change the active count.
- R10: While tc_flag is set, a write with cfg_stop=1 clears tc_flag and releases scl_hold with one stop_req pulse. A write with cfg_start=1 clears tc_flag and scl_hold without stop_req.
- R11: soft_rst=1 or periph_en=0 clears tc_flag, tcr_flag, pec_slot, stop_req and scl_hold by the next clock.
- R12: A count of 0 triggers the end action right after start_sent, with no byte_done pulses needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| periph_en | input | 1 | Peripheral enable; 0 clears the sequencer |
| soft_rst | input | 1 | Soft reset; 1 clears the sequencer |
| cfg_we | input | 1 | Register write strobe |
| cfg_count | input | 8 | Segment byte count |
| cfg_autoend | input | 1 | 1 = automatic STOP at end of count |
| cfg_reload | input | 1 | 1 = reload mode at end of count |
| cfg_pec_set | input | 1 | Write 1 to request a PEC byte |
| cfg_start | input | 1 | Write 1 to request a START |
| cfg_stop | input | 1 | Write 1 to request a STOP |
| start_sent | input | 1 | Pulse: START and address phase finished |
| byte_done | input | 1 | Pulse: one byte moved by the shift engine |
| addr_match | input | 1 | Pulse: address match reported |
| bus_stop_seen | input | 1 | Pulse: STOP condition seen on the bus |
| stop_req | output | 1 | One-cycle STOP request to the bit engine |
| scl_hold | output | 1 | Hold SCL low |
| tc_flag | output | 1 | Transfer complete |
| tcr_flag | output | 1 | Transfer complete, reload expected |
| pec_slot | output | 1 | The next byte is the PEC byte |

## Verification
The assertions assume that byte_done, start_sent, addr_match and bus_stop_seen are single-cycle pulses, and that byte_done comes only while the sequencer is counting or awaiting the PEC byte. The bench keeps to this. Every input goes high for exactly one clock, and the bench sends a byte only after it has confirmed that no end flag is raised. It also leaves several idle clocks between events, so that no stimulus lands in the same cycle as an end action.

// File: rtl/i2c_bcs_pkg.sv
package i2c_bcs_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_PEC,
    SEQ_HOLD_TC,
    SEQ_HOLD_TCR
  } seq_state_e;
endpackage

// File: rtl/bcs_cfg_regs.sv
module bcs_cfg_regs #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_autoend,
  input  logic             cfg_reload,
  input  logic             cfg_pec_set,
  input  logic             cfg_start,
  input  logic             start_sent,
  input  logic             pec_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             autoend_q,
  output logic             reload_q,
  output logic             pec_q,
  output logic             start_pend_q,
  output logic             count_load
);
  logic [CNT_W-1:0] count_d;
  logic             autoend_d, reload_d, pec_d, start_pend_d;

  // Count accepted only when no START is waiting
  assign count_load = cfg_we && !start_pend_q;

  always_comb begin
    count_d      = count_q;
    autoend_d    = autoend_q;
    reload_d     = reload_q;
    pec_d        = pec_q;
    start_pend_d = start_pend_q;
    if (count_load) count_d = cfg_count;
    if (cfg_we) begin
      autoend_d = cfg_autoend;
      reload_d  = cfg_reload;
    end
    if (cfg_we && cfg_pec_set) pec_d = 1'b1;
    if (pec_clr)               pec_d = 1'b0;
    if (start_sent)                 start_pend_d = 1'b0;
    if (cfg_we && cfg_start)        start_pend_d = 1'b1;
    if (kill) begin
      pec_d        = 1'b0;
      start_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q      <= '0;
      autoend_q    <= 1'b0;
      reload_q     <= 1'b0;
      pec_q        <= 1'b0;
      start_pend_q <= 1'b0;
    end else begin
      count_q      <= count_d;
      autoend_q    <= autoend_d;
      reload_q     <= reload_d;
      pec_q        <= pec_d;
      start_pend_q <= start_pend_d;
    end
  end
endmodule

// File: rtl/bcs_byte_ctr.sv
module bcs_byte_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  logic [CNT_W-1:0] done_q, done_d;

  assign reached = (done_q == limit);

  always_comb begin
    done_d = done_q;
    if (inc)         done_d = done_q + 1'b1;
    if (clr || kill) done_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= done_d;
  end
endmodule

// File: rtl/bcs_end_fsm.sv
module bcs_end_fsm
  import i2c_bcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic start_sent,
  input  logic start_pend,
  input  logic byte_done,
  input  logic reached,
  input  logic reload_q,
  input  logic autoend_q,
  input  logic pec_q,
  input  logic cfg_we,
  input  logic cfg_start,
  input  logic cfg_stop,
  input  logic count_load,
  output logic ctr_clr,
  output logic ctr_inc,
  output logic pec_done,
  output logic stop_req,
  output logic scl_hold,
  output logic tc_flag,
  output logic tcr_flag,
  output logic pec_slot
);
  seq_state_e state_q, state_d;
  logic       stop_q, stop_d;

  always_comb begin
    state_d  = state_q;
    stop_d   = 1'b0;
    ctr_clr  = 1'b0;
    pec_done = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (start_sent && start_pend) begin
        state_d = SEQ_RUN;
        ctr_clr = 1'b1;
      end
      SEQ_RUN: if (reached) begin
        if (reload_q)       state_d = SEQ_HOLD_TCR;
        else if (pec_q)     state_d = SEQ_PEC;
        else if (autoend_q) begin
          state_d = SEQ_IDLE;
          stop_d  = 1'b1;
        end else            state_d = SEQ_HOLD_TC;
      end
      SEQ_PEC: if (byte_done || !pec_q) begin
        pec_done = byte_done;
        if (autoend_q) begin
          state_d = SEQ_IDLE;
          stop_d  = 1'b1;
        end else state_d = SEQ_HOLD_TC;
      end
      SEQ_HOLD_TC: begin
        if (cfg_we && cfg_stop) begin
          state_d = SEQ_IDLE;
          stop_d  = 1'b1;
        end else if (cfg_we && cfg_start) state_d = SEQ_IDLE;
      end
      SEQ_HOLD_TCR: if (count_load) begin
        state_d = SEQ_RUN;
        ctr_clr = 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (kill) begin
      state_d = SEQ_IDLE;
      stop_d  = 1'b0;
    end
  end

  assign ctr_inc  = byte_done && (state_q == SEQ_RUN) && !reached;
  assign tc_flag  = (state_q == SEQ_HOLD_TC);
  assign tcr_flag = (state_q == SEQ_HOLD_TCR);
  assign scl_hold = tc_flag || tcr_flag;
  assign pec_slot = (state_q == SEQ_PEC) && pec_q;
  assign stop_req = stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
    end
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             soft_rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_autoend,
  input  logic             cfg_reload,
  input  logic             cfg_pec_set,
  input  logic             cfg_start,
  input  logic             cfg_stop,
  input  logic             start_sent,
  input  logic             byte_done,
  input  logic             addr_match,
  input  logic             bus_stop_seen,
  output logic             stop_req,
  output logic             scl_hold,
  output logic             tc_flag,
  output logic             tcr_flag,
  output logic             pec_slot
);
  logic             kill;
  logic [CNT_W-1:0] count_q;
  logic             autoend_q, reload_q, pec_q, start_pend_q, count_load;
  logic             ctr_clr, ctr_inc, reached, pec_done, pec_clr;

  assign kill    = soft_rst || !periph_en;
  assign pec_clr = pec_done || bus_stop_seen || addr_match;

  bcs_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .kill         (kill),
    .cfg_we       (cfg_we),
    .cfg_count    (cfg_count),
    .cfg_autoend  (cfg_autoend),
    .cfg_reload   (cfg_reload),
    .cfg_pec_set  (cfg_pec_set),
    .cfg_start    (cfg_start),
    .start_sent   (start_sent),
    .pec_clr      (pec_clr),
    .count_q      (count_q),
    .autoend_q    (autoend_q),
    .reload_q     (reload_q),
    .pec_q        (pec_q),
    .start_pend_q (start_pend_q),
    .count_load   (count_load)
  );

  bcs_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (kill),
    .clr     (ctr_clr),
    .inc     (ctr_inc),
    .limit   (count_q),
    .reached (reached)
  );

  bcs_end_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (kill),
    .start_sent (start_sent),
    .start_pend (start_pend_q),
    .byte_done  (byte_done),
    .reached    (reached),
    .reload_q   (reload_q),
    .autoend_q  (autoend_q),
    .pec_q      (pec_q),
    .cfg_we     (cfg_we),
    .cfg_start  (cfg_start),
    .cfg_stop   (cfg_stop),
    .count_load (count_load),
    .ctr_clr    (ctr_clr),
    .ctr_inc    (ctr_inc),
    .pec_done   (pec_done),
    .stop_req   (stop_req),
    .scl_hold   (scl_hold),
    .tc_flag    (tc_flag),
    .tcr_flag   (tcr_flag),
    .pec_slot   (pec_slot)
  );
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic periph_en,
  input logic soft_rst,
  input logic stop_req,
  input logic scl_hold,
  input logic tc_flag,
  input logic tcr_flag,
  input logic pec_slot,
  input logic reload_q
);
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tc_flag && tcr_flag));

  a_r4_tcr_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    tcr_flag |-> scl_hold);

  a_r3_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req);

  a_r3_stop_releases_scl: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !scl_hold);

  a_r7_no_pec_under_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pec_slot) |-> !$past(reload_q));

  a_r11_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || !periph_en) |=> !(tc_flag || tcr_flag || pec_slot || stop_req || scl_hold));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .periph_en (periph_en),
  .soft_rst  (soft_rst),
  .stop_req  (stop_req),
  .scl_hold  (scl_hold),
  .tc_flag   (tc_flag),
  .tcr_flag  (tcr_flag),
  .pec_slot  (pec_slot),
  .reload_q  (reload_q)
);

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en = 1'b1, soft_rst = 1'b0;
  logic cfg_we = 1'b0, cfg_autoend = 1'b0, cfg_reload = 1'b0;
  logic cfg_pec_set = 1'b0, cfg_start = 1'b0, cfg_stop = 1'b0;
  logic [7:0] cfg_count = '0;
  logic start_sent = 1'b0, byte_done = 1'b0, addr_match = 1'b0, bus_stop_seen = 1'b0;
  logic stop_req, scl_hold, tc_flag, tcr_flag, pec_slot;

  int checks = 0, failures = 0, stops = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_count(cfg_count), .cfg_autoend(cfg_autoend),
    .cfg_reload(cfg_reload), .cfg_pec_set(cfg_pec_set), .cfg_start(cfg_start),
    .cfg_stop(cfg_stop), .start_sent(start_sent), .byte_done(byte_done),
    .addr_match(addr_match), .bus_stop_seen(bus_stop_seen),
    .stop_req(stop_req), .scl_hold(scl_hold), .tc_flag(tc_flag),
    .tcr_flag(tcr_flag), .pec_slot(pec_slot)
  );

  always @(posedge clk) if (stop_req) stops <= stops + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int cnt, input bit ae, input bit rl, input bit pe,
                    input bit st, input bit sp);
    @(negedge clk);
    cfg_we = 1; cfg_count = 8'(cnt); cfg_autoend = ae; cfg_reload = rl;
    cfg_pec_set = pe; cfg_start = st; cfg_stop = sp;
    @(negedge clk);
    cfg_we = 0; cfg_pec_set = 0; cfg_start = 0; cfg_stop = 0;
  endtask

  task automatic pulse_start();
    start_sent = 1; @(negedge clk); start_sent = 0;
  endtask

  task automatic pulse_byte();
    byte_done = 1; @(negedge clk); byte_done = 0;
  endtask

  // Feed n bytes; the last one is the PEC slot when pec_last is set
  task automatic feed(input string req, input int n, input bit pec_last);
    for (int i = 0; i < n; i++) begin
      idle(3);
      chk({req, " no end flag yet"}, tc_flag + tcr_flag, 0);
      chk({req, " R6 pec_slot"}, pec_slot, (pec_last && i == n - 1) ? 1 : 0);
      pulse_byte();
    end
    idle(3);
  endtask

  task automatic kill();
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0; idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0;
    idle(2);
    chk("R1 stop_req", stop_req, 0);
    chk("R1 scl_hold", scl_hold, 0);
    chk("R1 tc", tc_flag, 0);
    chk("R1 tcr", tcr_flag, 0);
    chk("R1 pec_slot", pec_slot, 0);
    @(negedge clk); rst_n = 1; idle(2);

    // Sweep: counts 0..5 (R12 for 0) across every mode combination
    for (int cnt = 0; cnt <= 5; cnt++) begin
      for (int m = 0; m < 8; m++) begin
        bit ae, rl, pe;
        int nb;
        ae = m[0]; rl = m[1]; pe = m[2];
        nb = cnt + ((pe && !rl) ? 1 : 0);
        s0 = stops;
        wr(cnt, ae, rl, pe, 1, 0);
        pulse_start();
        feed(cnt == 0 ? "R12" : "R2", nb, pe && !rl);
        if (rl) begin
          chk("R4 tcr", tcr_flag, 1);
          chk("R4 hold", scl_hold, 1);
          chk("R4 no stop", stops - s0, 0);
          chk("R4 tc clear", tc_flag, 0);
          // R5: fresh count, autoend now on; pending PEC (R7) becomes active
          wr(2, 1, 0, 0, 0, 0);
          idle(1);
          chk("R5 tcr cleared", tcr_flag, 0);
          chk("R5 hold released", scl_hold, 0);
          feed("R5", 2 + (pe ? 1 : 0), pe);
          chk("R5 stop after resume", stops - s0, 1);
        end else if (ae) begin
          chk("R3 one stop", stops - s0, 1);
          chk("R3 tc clear", tc_flag, 0);
          chk("R3 hold clear", scl_hold, 0);
        end else begin
          chk("R2 tc", tc_flag, 1);
          chk("R2 hold", scl_hold, 1);
          chk("R2 no stop", stops - s0, 0);
          if (cnt % 2 == 0) begin
            wr(0, 0, 0, 0, 0, 1); idle(2);
            chk("R10 stop write pulse", stops - s0, 1);
          end else begin
            wr(0, 0, 0, 0, 1, 0); idle(2);
            chk("R10 start write no stop", stops - s0, 0);
            kill();
          end
          chk("R10 tc cleared", tc_flag, 0);
          chk("R10 hold released", scl_hold, 0);
        end
        chk("R6 pec_slot idle", pec_slot, 0);
      end
    end

    // R9: count write during pending START is rejected
    wr(3, 0, 0, 0, 1, 0);
    wr(7, 0, 0, 0, 0, 0);
    pulse_start();
    feed("R9", 3, 0);
    chk("R9 tc after original count", tc_flag, 1);
    kill();

    // R7: write of 0 to PEC request keeps it
    wr(0, 0, 0, 1, 0, 0);
    wr(1, 0, 0, 0, 1, 0);
    pulse_start();
    feed("R7", 2, 1);
    chk("R7 tc after PEC byte", tc_flag, 1);
    kill();

    // R8: address match clears the request
    wr(0, 0, 0, 1, 0, 0);
    @(negedge clk); addr_match = 1; @(negedge clk); addr_match = 0;
    wr(1, 0, 0, 0, 1, 0);
    pulse_start();
    feed("R8 addr", 1, 0);
    chk("R8 addr no pec", tc_flag, 1);
    kill();

    // R8: bus STOP clears the request
    wr(0, 0, 0, 1, 0, 0);
    @(negedge clk); bus_stop_seen = 1; @(negedge clk); bus_stop_seen = 0;
    wr(1, 0, 0, 0, 1, 0);
    pulse_start();
    feed("R8 stop", 1, 0);
    chk("R8 stop no pec", tc_flag, 1);
    kill();

    // R8: soft reset clears the request
    wr(0, 0, 0, 1, 0, 0);
    kill();
    wr(1, 0, 0, 0, 1, 0);
    pulse_start();
    feed("R8 softrst", 1, 0);
    chk("R8 softrst no pec", tc_flag, 1);

    // R11: enable low clears a held TC
    @(negedge clk); periph_en = 0; @(negedge clk);
    chk("R11 tc", tc_flag, 0);
    chk("R11 hold", scl_hold, 0);
    periph_en = 1;

    // R11: soft reset clears a held TCR and a PEC slot
    wr(1, 0, 1, 0, 1, 0);
    pulse_start();
    feed("R11", 1, 0);
    chk("R11 tcr set", tcr_flag, 1);
    @(negedge clk); soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk("R11 tcr cleared", tcr_flag, 0);
    wr(0, 0, 0, 1, 1, 0);
    pulse_start(); idle(3);
    chk("R11 pec_slot set", pec_slot, 1);
    @(negedge clk); periph_en = 0; @(negedge clk); periph_en = 1;
    chk("R11 pec_slot cleared", pec_slot, 0);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule